// File: doc/BRIEF.md
# PC-Relative Target and Alignment Checker

This unit sits in the execute stage of a 32-bit core. Each cycle it takes one decoded operation: the instruction's own PC, an operation class, a taken flag for conditional branches, the immediates and a base register value. From these it works out the value to write to the destination register, the next PC, and whether the control transfer goes to an instruction address that is not aligned. When the target is misaligned it raises an exception and reports the faulting target address.

The operation classes are: add-upper-immediate-to-PC, jump-and-link, register-indirect jump-and-link, and conditional branch. Any other operation steps to the next sequential instruction. The parameter `IALIGN` sets the instruction alignment. With 32, targets must be four-byte aligned. With 16, only two-byte alignment is needed.

All results are registered. A result appears on the outputs one clock after the input was accepted with `valid_i` high.

Top module: `pcrel_tgt_unit`

## Requirements
- R1: While `rst_ni` is low, and until the first accepted operation, `valid_o`, `rd_we_o`, `excp_o`, `rd_data_o`, `npc_o` and `excp_tval_o` are all zero.
- R2: For op code 1 (add upper immediate to PC), `rd_data_o` equals `pc_i + {imm_u_i, 12'b0}`, where `pc_i` is the PC of that same instruction. `rd_we_o` is 1 and `npc_o` is `pc_i + 4`. An immediate of zero returns `pc_i`.
- R3: For op code 2 (jump and link), `rd_data_o` is `pc_i + 4` and `npc_o` is `pc_i` plus `off_i` sign-extended from 21 bits.
- R4: For op code 3 (indirect jump and link), the target is `base_i` plus `imm12_i` sign-extended, with bit 0 then cleared. The link value is `pc_i + 4`.
- R5: For op code 4 (conditional branch) with `taken_i` = 1, `npc_o` is `pc_i` plus the sign-extended `off_i`, and `rd_we_o` is 0.
- R6: A conditional branch with `taken_i` = 0 gives `npc_o` = `pc_i + 4`. It never raises `excp_o`, even when its computed target is misaligned.
- R7: With `IALIGN` = 32, a taken transfer whose target has a nonzero value in bits 1:0 raises `excp_o`.
- R8: With `IALIGN` = 16, only bit 0 of the target is checked, so a target that is two bytes off is accepted.
- R9: When `excp_o` is 1, `rd_we_o` is 0, `npc_o` holds the faulting instruction's own PC, and `excp_tval_o` carries the misaligned target.
- R10: Op code 0, and op codes 5 to 7, give `npc_o` = `pc_i + 4` with no register write and no exception.
- R11: Results appear exactly one clock after acceptance. A cycle with `valid_i` low gives `valid_o`, `rd_we_o` and `excp_o` equal to 0 on the next cycle.
- R12: All additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation class: 0 none, 1 add-upper-to-PC, 2 jump-and-link, 3 indirect jump-and-link, 4 branch |
| taken_i | input | 1 | Branch outcome |
| pc_i | input | 32 | PC of this instruction |
| imm_u_i | input | 20 | Upper immediate |
| off_i | input | 21 | PC-relative offset for branch and jump, sign-extended internally |
| imm12_i | input | 12 | Offset for the indirect jump |
| base_i | input | 32 | Base register value for the indirect jump |
| valid_o | output | 1 | Result valid |
| rd_we_o | output | 1 | Destination register write enable |
| rd_data_o | output | 32 | Destination register value |
| npc_o | output | 32 | Next PC, or the faulting PC when an exception is raised |
| excp_o | output | 1 | Instruction address misaligned |
| excp_tval_o | output | 32 | Misaligned target address |

## Verification
An operand-select fault or an adder fault shows up as a wrong `rd_data_o` or `npc_o` on the cycle right after the faulty operation. An alignment mask that ignores `IALIGN` shows up as a wrong `excp_o` on targets that are two bytes off. The two bench instances, one per `IALIGN` setting, give different answers for those targets. A missing gate on the taken flag or on the write enable shows up as a spurious exception or a register write on the same cycle that the result comes out. Because the output register holds no state from one operation to the next, every fault can be seen within one cycle.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_AUIPC  = 3'd1,
    OP_JAL    = 3'd2,
    OP_JALR   = 3'd3,
    OP_BRANCH = 3'd4
  } op_e;

  typedef struct packed {
    logic        rd_we;
    logic [31:0] rd_data;
    logic [31:0] npc;
    logic        excp;
    logic [31:0] tval;
  } result_t;
endpackage

// File: rtl/pcrel_adder.sv
module pcrel_adder #(
  parameter int XLEN       = 32,
  parameter int UIMM_W     = 20,
  parameter int OFF_W      = 21,
  parameter int IMM12_W    = 12,
  parameter int ILEN_BYTES = 4
) (
  input  logic [XLEN-1:0]    pc_i,
  input  logic [UIMM_W-1:0]  imm_u_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [IMM12_W-1:0] imm12_i,
  input  logic [XLEN-1:0]    base_i,
  output logic [XLEN-1:0]    seq_pc_o,
  output logic [XLEN-1:0]    upper_sum_o,
  output logic [XLEN-1:0]    rel_tgt_o,
  output logic [XLEN-1:0]    ind_tgt_o
);
  localparam int LOW_W = XLEN - UIMM_W;

  logic [XLEN-1:0] upper_off, rel_off, ind_off, ind_raw;

  always_comb begin
    upper_off = {imm_u_i, {LOW_W{1'b0}}};
    rel_off   = {{(XLEN-OFF_W){off_i[OFF_W-1]}}, off_i};
    ind_off   = {{(XLEN-IMM12_W){imm12_i[IMM12_W-1]}}, imm12_i};
    seq_pc_o    = pc_i + XLEN'(ILEN_BYTES);
    upper_sum_o = pc_i + upper_off;
    rel_tgt_o   = pc_i + rel_off;
    ind_raw     = base_i + ind_off;
    ind_tgt_o   = {ind_raw[XLEN-1:1], 1'b0};
  end
endmodule

// File: rtl/pcrel_align_chk.sv
module pcrel_align_chk #(
  parameter int XLEN   = 32,
  parameter int IALIGN = 32
) (
  input  logic [XLEN-1:0] tgt_i,
  output logic            mis_o
);
  localparam int LOW_BITS = (IALIGN == 16) ? 1 : 2;

  generate
    if (LOW_BITS == 1) begin : g_half
      assign mis_o = tgt_i[0];
    end else begin : g_word
      assign mis_o = |tgt_i[LOW_BITS-1:0];
    end
  endgenerate
endmodule

// File: rtl/pcrel_out_reg.sv
module pcrel_out_reg
  import pcrel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  result_t         res_i,
  output logic            valid_o,
  output logic            rd_we_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic [XLEN-1:0] npc_o,
  output logic            excp_o,
  output logic [XLEN-1:0] tval_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      rd_we_o   <= 1'b0;
      rd_data_o <= '0;
      npc_o     <= '0;
      excp_o    <= 1'b0;
      tval_o    <= '0;
    end else if (valid_i) begin
      valid_o   <= 1'b1;
      rd_we_o   <= res_i.rd_we;
      rd_data_o <= res_i.rd_data;
      npc_o     <= res_i.npc;
      excp_o    <= res_i.excp;
      tval_o    <= res_i.tval;
    end else begin
      // idle: drop strobes, hold data
      valid_o <= 1'b0;
      rd_we_o <= 1'b0;
      excp_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/pcrel_tgt_unit.sv
module pcrel_tgt_unit
  import pcrel_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IALIGN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [2:0]  op_i,
  input  logic        taken_i,
  input  logic [31:0] pc_i,
  input  logic [19:0] imm_u_i,
  input  logic [20:0] off_i,
  input  logic [11:0] imm12_i,
  input  logic [31:0] base_i,
  output logic        valid_o,
  output logic        rd_we_o,
  output logic [31:0] rd_data_o,
  output logic [31:0] npc_o,
  output logic        excp_o,
  output logic [31:0] excp_tval_o
);
  localparam int ILEN_BYTES = 4;

  op_e             op;
  logic [XLEN-1:0] seq_pc, upper_sum, rel_tgt, ind_tgt, tgt;
  logic            xfer, link, mis;
  result_t         res;

  assign op = op_e'(op_i);

  pcrel_adder #(
    .XLEN(XLEN), .UIMM_W(20), .OFF_W(21), .IMM12_W(12), .ILEN_BYTES(ILEN_BYTES)
  ) u_add (
    .pc_i       (pc_i),
    .imm_u_i    (imm_u_i),
    .off_i      (off_i),
    .imm12_i    (imm12_i),
    .base_i     (base_i),
    .seq_pc_o   (seq_pc),
    .upper_sum_o(upper_sum),
    .rel_tgt_o  (rel_tgt),
    .ind_tgt_o  (ind_tgt)
  );

  pcrel_align_chk #(.XLEN(XLEN), .IALIGN(IALIGN)) u_align (
    .tgt_i(tgt),
    .mis_o(mis)
  );

  always_comb begin
    tgt  = rel_tgt;
    xfer = 1'b0;
    link = 1'b0;
    unique case (op)
      OP_JAL:    begin xfer = 1'b1; link = 1'b1; end
      OP_JALR:   begin xfer = 1'b1; link = 1'b1; tgt = ind_tgt; end
      OP_BRANCH: xfer = taken_i;
      default:   ;
    endcase
  end

  always_comb begin
    res = '0;
    res.npc = seq_pc;
    if (op == OP_AUIPC) begin
      res.rd_we   = 1'b1;
      res.rd_data = upper_sum;
    end else if (xfer && mis) begin
      // faulting transfer: PC stays, no write
      res.excp = 1'b1;
      res.tval = tgt;
      res.npc  = pc_i;
    end else begin
      if (xfer) res.npc = tgt;
      if (link) begin
        res.rd_we   = 1'b1;
        res.rd_data = seq_pc;
      end
    end
  end

  pcrel_out_reg #(.XLEN(XLEN)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .res_i    (res),
    .valid_o  (valid_o),
    .rd_we_o  (rd_we_o),
    .rd_data_o(rd_data_o),
    .npc_o    (npc_o),
    .excp_o   (excp_o),
    .tval_o   (excp_tval_o)
  );
endmodule

// File: rtl/pcrel_tgt_chk.sv
module pcrel_tgt_chk #(
  parameter int XLEN   = 32,
  parameter int IALIGN = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic        taken_i,
  input logic [31:0] pc_i,
  input logic [19:0] imm_u_i,
  input logic        valid_o,
  input logic        rd_we_o,
  input logic [31:0] rd_data_o,
  input logic [31:0] npc_o,
  input logic        excp_o,
  input logic [31:0] excp_tval_o
);
  localparam logic [31:0] MIS_MASK = (IALIGN == 16) ? 32'h1 : 32'h3;

  // R9
  excp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excp_o |-> (!rd_we_o && valid_o));

  // R7
  excp_tgt_mis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excp_o |-> ((excp_tval_o & MIS_MASK) != 32'h0));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !rd_we_o && !excp_o));

  // R6
  not_taken_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && !taken_i) |=>
      (!excp_o && npc_o == $past(pc_i) + 32'd4));

  // R2
  upper_own_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1) |=>
      (rd_we_o && rd_data_o == $past(pc_i) + {$past(imm_u_i), 12'h000}));

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !rd_we_o && !excp_o));
endmodule

bind pcrel_tgt_unit pcrel_tgt_chk #(.XLEN(XLEN), .IALIGN(IALIGN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .taken_i    (taken_i),
  .pc_i       (pc_i),
  .imm_u_i    (imm_u_i),
  .valid_o    (valid_o),
  .rd_we_o    (rd_we_o),
  .rd_data_o  (rd_data_o),
  .npc_o      (npc_o),
  .excp_o     (excp_o),
  .excp_tval_o(excp_tval_o)
);

// File: tb/sim_pcrel_tgt_unit.sv
`timescale 1ns/1ps
module sim_pcrel_tgt_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        taken_i = 1'b0;
  logic [31:0] pc_i = '0, base_i = '0;
  logic [19:0] imm_u_i = '0;
  logic [20:0] off_i = '0;
  logic [11:0] imm12_i = '0;

  logic        v0, we0, ex0, v1, we1, ex1;
  logic [31:0] rd0, np0, tv0, rd1, np1, tv1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcrel_tgt_unit #(.IALIGN(32)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .taken_i(taken_i),
    .pc_i(pc_i), .imm_u_i(imm_u_i), .off_i(off_i), .imm12_i(imm12_i), .base_i(base_i),
    .valid_o(v0), .rd_we_o(we0), .rd_data_o(rd0), .npc_o(np0), .excp_o(ex0), .excp_tval_o(tv0));

  pcrel_tgt_unit #(.IALIGN(16)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .taken_i(taken_i),
    .pc_i(pc_i), .imm_u_i(imm_u_i), .off_i(off_i), .imm12_i(imm12_i), .base_i(base_i),
    .valid_o(v1), .rd_we_o(we1), .rd_data_o(rd1), .npc_o(np1), .excp_o(ex1), .excp_tval_o(tv1));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic void model(input int ialign, input logic [2:0] op, input logic tk,
      input logic [31:0] pc, input logic [19:0] u, input logic [20:0] off,
      input logic [11:0] i12, input logic [31:0] base,
      output logic we, output logic [31:0] rd, output logic [31:0] npc,
      output logic ex, output logic [31:0] tval);
    logic [31:0] tgt;
    logic xfer, lnk;
    xfer = 1'b0; lnk = 1'b0; tgt = pc + {{11{off[20]}}, off};
    we = 1'b0; rd = 32'h0; npc = pc + 32'd4; ex = 1'b0; tval = 32'h0;
    case (op)
      3'd1: begin we = 1'b1; rd = pc + {u, 12'h000}; end
      3'd2: begin xfer = 1'b1; lnk = 1'b1; end
      3'd3: begin xfer = 1'b1; lnk = 1'b1;
                  tgt = (base + {{20{i12[11]}}, i12}) & 32'hFFFF_FFFE; end
      3'd4: xfer = tk;
      default: ;
    endcase
    if (xfer && ((ialign == 16) ? tgt[0] : (tgt[1:0] != 2'b00))) begin
      ex = 1'b1; tval = tgt; npc = pc;
    end else begin
      if (xfer) npc = tgt;
      if (lnk) begin we = 1'b1; rd = pc + 32'd4; end
    end
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic tk);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return tk ? "R5" : "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check_one(input string req, input int ialign, input logic v, input logic we,
      input logic [31:0] rd, input logic [31:0] np, input logic ex, input logic [31:0] tv);
    logic ewe, eex;
    logic [31:0] erd, enp, etv;
    model(ialign, op_i, taken_i, pc_i, imm_u_i, off_i, imm12_i, base_i, ewe, erd, enp, eex, etv);
    chk("R11", "valid_o", {31'b0, v}, 32'd1);
    chk(req, "rd_we_o", {31'b0, we}, {31'b0, ewe});
    if (ewe) chk(req, "rd_data_o", rd, erd);
    chk(req, "npc_o", np, enp);
    chk(eex ? "R9" : req, "excp_o", {31'b0, ex}, {31'b0, eex});
    if (eex) chk("R9", "excp_tval_o", tv, etv);
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic apply(input string req, input logic [2:0] op, input logic tk, input logic [31:0] pc,
      input logic [19:0] u, input logic [20:0] off, input logic [11:0] i12, input logic [31:0] base);
    valid_i = 1'b1; op_i = op; taken_i = tk; pc_i = pc; imm_u_i = u;
    off_i = off; imm12_i = i12; base_i = base;
    @(negedge clk);
    check_one(req, 32, v0, we0, rd0, np0, ex0, tv0);
    check_one(req, 16, v1, we1, rd1, np1, ex1, tv1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid_o", {31'b0, v0}, 32'd0);
    chk("R1", "excp_o", {31'b0, ex0 | ex1}, 32'd0);
    chk("R1", "npc_o", np0, 32'd0);
    chk("R1", "rd_data_o", rd1, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "valid_o idle", {31'b0, v0 | v1}, 32'd0);

    apply("R2", 3'd1, 1'b0, 32'h0000_4000, 20'h00000, 21'h0, 12'h0, 32'h0);   // zero imm -> own PC
    apply("R2", 3'd1, 1'b0, 32'h1234_5678, 20'hABCDE, 21'h0, 12'h0, 32'h0);
    apply("R12", 3'd1, 1'b0, 32'hFFFF_F000, 20'h00002, 21'h0, 12'h0, 32'h0);  // wraps
    apply("R3", 3'd2, 1'b0, 32'h0000_1000, 20'h0, 21'h1FFFF8, 12'h0, 32'h0);  // backward
    apply("R12", 3'd2, 1'b0, 32'hFFFF_FFFC, 20'h0, 21'h000010, 12'h0, 32'h0);
    apply("R4", 3'd3, 1'b0, 32'h0000_2000, 20'h0, 21'h0, 12'h000, 32'h0000_1001); // bit0 cleared
    apply("R4", 3'd3, 1'b0, 32'h0000_2000, 20'h0, 21'h0, 12'hFFE, 32'h0000_1004);
    apply("R8", 3'd3, 1'b0, 32'h0000_2000, 20'h0, 21'h0, 12'h002, 32'h0000_1000); // R7 on u0 only
    apply("R5", 3'd4, 1'b1, 32'h0000_0100, 20'h0, 21'h000040, 12'h0, 32'h0);
    apply("R7", 3'd4, 1'b1, 32'h0000_0100, 20'h0, 21'h000002, 12'h0, 32'h0);    // R8 ok on u1
    apply("R9", 3'd2, 1'b0, 32'h0000_0200, 20'h0, 21'h000001, 12'h0, 32'h0);    // both fault
    apply("R6", 3'd4, 1'b0, 32'h0000_0300, 20'h0, 21'h000003, 12'h0, 32'h0);
    apply("R10", 3'd0, 1'b1, 32'h0000_0400, 20'hFFFFF, 21'h000001, 12'h0, 32'h0);
    apply("R10", 3'd6, 1'b1, 32'h0000_0500, 20'h12345, 21'h000002, 12'h0, 32'h0);

    valid_i = 1'b0;
    @(negedge clk);
    // R11 idle
    chk("R11", "valid_o idle", {31'b0, v0 | v1}, 32'd0);
    chk("R11", "rd_we_o idle", {31'b0, we0 | we1}, 32'd0);
    chk("R11", "excp_o idle", {31'b0, ex0 | ex1}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic tk;
      op = 3'($urandom_range(0, 5));
      tk = 1'($urandom);
      apply(tag_of(op, tk), op, tk, $urandom & 32'hFFFF_FFFC, 20'($urandom),
            21'($urandom), 12'($urandom), $urandom);
      if ((i % 7) == 0) begin
        valid_i = 1'b0;
        @(negedge clk);
        chk("R11", "valid_o gap", {31'b0, v0 | v1}, 32'd0);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule